// File: doc/BRIEF.md
# Weighted Hysteresis Threshold Gate

This block is a threshold gate with hysteresis, modelled as a clocked register. It has a set of single-bit inputs, and each input carries a fixed integer weight. On every clock edge the block adds up the weights of the inputs that are high. If that total is at or above the threshold, the output is driven to 1. If every input is low, the output is driven to 0. In every other case the output keeps the value it already has.

Because of this hysteresis, the output changes at most once in each data phase. After the output has risen, it stays high through any partial input pattern. It falls only when all inputs have gone back to the empty state. Dual-rail completion trees and similar self-timed structures depend on this property, here evaluated at clocked sampling points.

The number of inputs, the weight of each input and the threshold are all fixed at elaboration time. The weights are packed into one vector, with input i at bits [i*WEIGHT_W +: WEIGHT_W].

Top module: `thg_gate`

## Requirements
- R1: While `rst` is high at a rising edge, `gate_q` is 0 after that edge.
- R2: If every bit of `in_rail` is 0 at a rising edge, `gate_q` is 0 after that edge.
- R3: If the weighted count of high inputs is at least `THRESH` at a rising edge, `gate_q` is 1 after that edge.
- R4: If some input is high but the weighted count is below `THRESH`, `gate_q` keeps its value across the edge.
- R5: Input i adds `WEIGHTS[i*WEIGHT_W +: WEIGHT_W]` to the count. With three inputs, weights 2, 1, 1 on inputs 0, 1, 2 and `THRESH`=2, the gate sets exactly when `in_rail[0] | (in_rail[1] & in_rail[2])`. `THRESH` must lie between 1 and the total weight, and this is checked at elaboration.
- R6: In that weighted configuration, a pattern with only `in_rail[1]` high, or only `in_rail[2]` high, leaves `gate_q` unchanged, whether it was 0 or 1.
- R7: Once `gate_q` is 1, it stays 1 for as long as any input remains high. It therefore rises at most once between two all-zero input phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_rail | input | N_IN | Input rails, 1 = data present |
| gate_q | output | 1 | Registered gate output |

## Verification
The assertions assume two things about the inputs. First, `in_rail` and `rst` are stable around each rising edge. Second, reset is held for at least one edge before any check counts. The bench meets both conditions. It changes every input only on the falling edge, and it starts each run with a reset step. Inside that envelope, the stimulus is free to move between empty, partial and complete patterns in any order. This lets the hold region be reached both from a set output and from a clear output. Three configurations are driven in parallel and compared against a weighted-count model: the weighted three-input gate, an unweighted three-of-three gate, and a four-input gate with mixed weights.

// File: rtl/thg_pkg.sv
package thg_pkg;

    // Decision region selected by the current input pattern
    typedef enum logic [1:0] {
        RG_HOLD  = 2'd0,
        RG_CLEAR = 2'd1,
        RG_SET   = 2'd2
    } region_e;

    // Registered state of the gate
    typedef struct packed {
        logic level;
    } gate_state_t;

endpackage

// File: rtl/thg_weight_sum.sv
module thg_weight_sum #(
    parameter int N_IN     = 3,
    parameter int WEIGHT_W = 4,
    parameter logic [N_IN*WEIGHT_W-1:0] WEIGHTS = '0,
    localparam int MAX_SUM = N_IN * ((1 << WEIGHT_W) - 1),
    localparam int SUM_W   = $clog2(MAX_SUM + 1)
) (
    input  logic [N_IN-1:0]  rail_i,
    output logic [SUM_W-1:0] count_o
);

    logic [SUM_W-1:0] term_w [N_IN];

    // One gated weight term per input
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_term
        localparam logic [WEIGHT_W-1:0] WGT = WEIGHTS[gi*WEIGHT_W +: WEIGHT_W];
        assign term_w[gi] = rail_i[gi] ? SUM_W'(WGT) : '0;
    end

    always_comb begin
        count_o = '0;
        for (int k = 0; k < N_IN; k++) begin
            count_o = count_o + term_w[k];
        end
    end

    // R5: an empty rail set contributes nothing to the count
    always_comb begin
        if (rail_i == '0) begin
            assert_empty_count_R5: assert (count_o == '0);
        end
    end

endmodule

// File: rtl/thg_region_decode.sv
module thg_region_decode
    import thg_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int SUM_W  = 4,
    parameter int THRESH = 2
) (
    input  logic [N_IN-1:0]  rail_i,
    input  logic [SUM_W-1:0] count_i,
    output region_e          region_o
);

    localparam logic [SUM_W-1:0] THRESH_V = SUM_W'(THRESH);

    logic none_high;
    logic reached;

    always_comb begin
        none_high = (rail_i == '0);
        reached   = (count_i >= THRESH_V);
        if (none_high) begin
            region_o = RG_CLEAR;
        end else if (reached) begin
            region_o = RG_SET;
        end else begin
            region_o = RG_HOLD;
        end
    end

endmodule

// File: rtl/thg_state_reg.sv
module thg_state_reg
    import thg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  region_e region_i,
    output logic    level_o
);

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (region_i)
            RG_CLEAR: st_d.level = 1'b0;
            RG_SET:   st_d.level = 1'b1;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

    // R3: the set region drives the level high on the next edge
    assert_set_level_R3: assert property (@(posedge clk) disable iff (rst)
        (region_i == RG_SET) |=> level_o);

    // R4: the hold region leaves the level untouched
    assert_hold_level_R4: assert property (@(posedge clk) disable iff (rst)
        (region_i == RG_HOLD) |=> $stable(level_o));

endmodule

// File: rtl/thg_gate.sv
module thg_gate #(
    parameter int N_IN     = 3,
    parameter int WEIGHT_W = 4,
    parameter logic [N_IN*WEIGHT_W-1:0] WEIGHTS = {4'd1, 4'd1, 4'd2},
    parameter int THRESH   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] in_rail,
    output logic            gate_q
);

    import thg_pkg::*;

    localparam int MAX_SUM = N_IN * ((1 << WEIGHT_W) - 1);
    localparam int SUM_W   = $clog2(MAX_SUM + 1);

    function automatic int total_weight();
        int acc = 0;
        for (int k = 0; k < N_IN; k++) begin
            acc += int'(WEIGHTS[k*WEIGHT_W +: WEIGHT_W]);
        end
        return acc;
    endfunction

    localparam int TOTAL_W = total_weight();

    logic [SUM_W-1:0] count_w;
    region_e          region_w;

    thg_weight_sum #(
        .N_IN    (N_IN),
        .WEIGHT_W(WEIGHT_W),
        .WEIGHTS (WEIGHTS)
    ) sum_i (
        .rail_i (in_rail),
        .count_o(count_w)
    );

    thg_region_decode #(
        .N_IN  (N_IN),
        .SUM_W (SUM_W),
        .THRESH(THRESH)
    ) dec_i (
        .rail_i  (in_rail),
        .count_i (count_w),
        .region_o(region_w)
    );

    thg_state_reg state_i (
        .clk     (clk),
        .rst     (rst),
        .region_i(region_w),
        .level_o (gate_q)
    );

    // R5: the threshold must be reachable and nonzero
    initial begin
        assert_thresh_legal_R5: assert (THRESH >= 1 && THRESH <= TOTAL_W);
    end

    // R1: reset clears the output
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !gate_q);

    // R2: an all-zero input phase clears the output
    assert_clear_low_R2: assert property (@(posedge clk) disable iff (rst)
        (in_rail == '0) |=> !gate_q);

    // R7: a high output survives any nonempty input pattern
    assert_no_early_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_q && in_rail != '0) |=> gate_q);

endmodule

// File: tb/thg_gate_tb_top.sv
module thg_gate_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] a_in = '0;
    logic [2:0] b_in = '0;
    logic [3:0] c_in = '0;
    logic a_q, b_q, c_q;

    int checks = 0;
    int failures = 0;
    bit ea, eb, ec;
    bit done = 0;

    always #2 clk = ~clk;

    // TH23 with weights 2,1,1
    thg_gate dut_i (.clk(clk), .rst(rst), .in_rail(a_in), .gate_q(a_q));

    // TH33 unweighted
    thg_gate #(.N_IN(3), .WEIGHT_W(4), .WEIGHTS({4'd1, 4'd1, 4'd1}), .THRESH(3))
        dut_th33_i (.clk(clk), .rst(rst), .in_rail(b_in), .gate_q(b_q));

    // TH34 with weights 2,2,1,1
    thg_gate #(.N_IN(4), .WEIGHT_W(4), .WEIGHTS({4'd1, 4'd1, 4'd2, 4'd2}), .THRESH(3))
        dut_th34_i (.clk(clk), .rst(rst), .in_rail(c_in), .gate_q(c_q));

    int wa [3] = '{2, 1, 1};
    int wb [3] = '{1, 1, 1};
    int wc [4] = '{2, 2, 1, 1};

    function automatic int wsum(int cfg, logic [3:0] v);
        int s = 0;
        for (int k = 0; k < 4; k++) begin
            if (v[k]) begin
                if (cfg == 0 && k < 3) s += wa[k];
                if (cfg == 1 && k < 3) s += wb[k];
                if (cfg == 2) s += wc[k];
            end
        end
        return s;
    endfunction

    function automatic bit model_next(bit cur, bit r, int s, int m, logic [3:0] v);
        if (r) return 1'b0;
        if (v == '0) return 1'b0;
        if (s >= m) return 1'b1;
        return cur;
    endfunction

    function automatic string region_tag(bit r, int s, int m, logic [3:0] v);
        if (r) return "R1";
        if (v == '0) return "R2";
        if (s >= m) return "R3";
        return "R4";
    endfunction

    task automatic check(string name, string tag, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, name, act, exp);
        end
    endtask

    task automatic step(bit r, logic [2:0] a, logic [2:0] b, logic [3:0] c, string extra);
        string ta, tb, tc;
        int sa, sb, sc;
        sa = wsum(0, {1'b0, a});
        sb = wsum(1, {1'b0, b});
        sc = wsum(2, c);
        ta = region_tag(r, sa, 2, {1'b0, a});
        tb = region_tag(r, sb, 3, {1'b0, b});
        tc = region_tag(r, sc, 3, c);
        rst  = r;
        a_in = a;
        b_in = b;
        c_in = c;
        ea = model_next(ea, r, sa, 2, {1'b0, a});
        eb = model_next(eb, r, sb, 3, {1'b0, b});
        ec = model_next(ec, r, sc, 3, c);
        @(negedge clk);
        check("th23w2", {extra, ta}, a_q, ea);
        check("th33",   tb, b_q, eb);
        check("th34w22", tc, c_q, ec);
    endtask

    initial begin
        @(negedge clk);
        // R1 reset state
        step(1, 3'b111, 3'b111, 4'b1111, "R1/");
        step(0, 3'b000, 3'b000, 4'b0000, "R2/");
        // R6: only the light inputs, from a low output
        step(0, 3'b010, 3'b010, 4'b0100, "R6/");
        step(0, 3'b100, 3'b100, 4'b1000, "R6/");
        // R5: both light inputs together reach the threshold
        step(0, 3'b110, 3'b110, 4'b1100, "R5/");
        // R6 and R7: one light input left, output stays high
        step(0, 3'b010, 3'b010, 4'b0100, "R6/R7/");
        step(0, 3'b100, 3'b100, 4'b1000, "R6/R7/");
        step(0, 3'b000, 3'b000, 4'b0000, "R2/");
        // R5: the heavy input alone reaches the threshold
        step(0, 3'b001, 3'b011, 4'b0011, "R5/");
        step(0, 3'b001, 3'b111, 4'b0001, "R7/");
        step(0, 3'b000, 3'b000, 4'b0000, "R2/");
        // R1: reset while the set condition holds
        step(0, 3'b111, 3'b111, 4'b1111, "R3/");
        step(1, 3'b111, 3'b111, 4'b1111, "R1/");
        step(0, 3'b010, 3'b001, 4'b0100, "R4/");
        // Random walk over all regions
        for (int n = 0; n < 400; n++) begin
            logic [3:0] rv;
            rv = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 4) == 0) rv = '0;
            step(($urandom_range(0, 40) == 0), rv[2:0], rv[3:1], rv, "");
        end
        done = 1;
    end

    initial begin
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule